// File: doc/BRIEF.md
# Rotating-Offset Line Wear Leveler

This block sits between a line compressor and a non-volatile memory array whose line slots are 64 bytes wide, cut into sixteen 4-byte segments. A compressed line needs fewer than sixteen segments. The block stores each line starting at the segment just after the end of the line that was written to the same slot before it. If the line runs past segment 15, it continues at segment 0. Repeated writes to one slot therefore spread over every segment of that slot, instead of wearing the low segments again and again.

For each slot the block keeps three things: the start segment and the length of the line now stored there, and a saturating write counter. When a write is accepted, the block rotates the payload into place and drives one write enable per segment of the slot. When a read is accepted, it takes the raw slot contents, rotates them back so that the line starts at segment 0, and passes them on with the stored length.

Both paths use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. Each path has one output register:
- An input is ready whenever its output register is empty, or is being emptied in the same cycle (`wr_ready = !dw_valid || dw_ready`, and likewise for reads).
- While an output is valid and not taken, all of its fields hold still.
- Once valid, an output stays valid until it is taken.

Top module: `rot_wear_leveler`

## Requirements
- R1: While reset is asserted and in the cycle after it, `dw_valid` and `rq_valid` are low. After reset, every slot holds start 0 and length 16 (length-minus-one field 15), and its counter is 0.
- R2: The first write to a slot after reset starts at segment 0. Its payload segment i goes to slot segment i.
- R3: Each later write to a slot starts at segment (previous start + previous length) mod 16.
- R4: Payload segment i is placed at slot segment (start + i) mod 16, and enables wrap from segment 15 to segment 0.
- R5: `dw_seg_en` has exactly length bits set, and they are the segments the line covers. A length-minus-one value of 15 (an uncompressed line) sets all 16 bits.
- R6: `dw_count` carries the slot's write counter after it has been incremented for this write.
- R7: The write counter saturates at 65535.
- R8: A read outputs raw segment (start + i) mod 16 as `rq_data` segment i, and gives the stored length on `rq_len_m1`. Both use the slot state as it stood before any write accepted in the same cycle.
- R9: Each output holds its valid flag and all of its fields stable while it is not taken. Each input's ready equals "output empty or output taken this cycle".
- R10: A write to one slot changes neither the start, the length nor the counter of any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle if valid |
| wr_slot | input | SLOT_W | Slot index to write |
| wr_len_m1 | input | 4 | Compressed length in segments, minus one |
| wr_data | input | 512 | Compressed line, segment 0 in bits 31:0 |
| dw_valid | output | 1 | Device write valid |
| dw_ready | input | 1 | Device takes the write |
| dw_slot | output | SLOT_W | Slot index for the device write |
| dw_data | output | 512 | Rotated line in slot order |
| dw_seg_en | output | 16 | Per-segment write enables |
| dw_count | output | 16 | Slot write counter after this write |
| rd_valid | input | 1 | Raw slot read data valid |
| rd_ready | output | 1 | Raw slot data accepted this cycle if valid |
| rd_slot | input | SLOT_W | Slot the raw data came from |
| rd_raw | input | 512 | Raw slot contents in slot order |
| rq_valid | output | 1 | Aligned line valid |
| rq_ready | input | 1 | Decompressor takes the line |
| rq_data | output | 512 | Line rotated back to start at segment 0 |
| rq_len_m1 | output | 4 | Stored length minus one |

## Verification
The write path is first exercised with a directed chain on one slot. The lengths are chosen so that successive starts land at 0, 5 and 8, then wrap to 2; this separates a start that accumulates lengths from one that stays fixed or is off by one segment. A full-length line checks that all 16 enables are set. Reads of a written slot and of an untouched slot show that the inverse rotation uses the correct slot's state. Random traffic across slots with random ready on both outputs checks the stall rules and how reads and writes to the same slot interleave. A long burst to one slot drives its counter into saturation.

// File: rtl/wlv_pkg.sv
package wlv_pkg;
  parameter int unsigned WL_NSEG  = 16;
  parameter int unsigned WL_SEG_W = 32;
  parameter int unsigned WL_CNT_W = 16;
  localparam int unsigned WL_IDX_W  = $clog2(WL_NSEG);
  localparam int unsigned WL_LINE_W = WL_NSEG * WL_SEG_W;

  typedef logic [WL_IDX_W-1:0] seg_idx_t;

  typedef struct packed {
    seg_idx_t              start;
    seg_idx_t              len_m1;
    logic [WL_CNT_W-1:0]   wcount;
  } slot_meta_t;
endpackage

// File: rtl/wlv_seg_rot.sv
module wlv_seg_rot
  import wlv_pkg::*;
#(
  parameter bit TO_SLOT = 1'b1
) (
  input  logic [WL_LINE_W-1:0] din,
  input  seg_idx_t             amt,
  output logic [WL_LINE_W-1:0] dout
);
  generate
    if (TO_SLOT) begin : g_place
      always_comb begin
        seg_idx_t k;
        dout = '0;
        for (int i = 0; i < WL_NSEG; i++) begin
          k = seg_idx_t'(i) + amt;
          dout[k*WL_SEG_W +: WL_SEG_W] = din[i*WL_SEG_W +: WL_SEG_W];
        end
      end
    end else begin : g_align
      always_comb begin
        seg_idx_t k;
        dout = '0;
        for (int i = 0; i < WL_NSEG; i++) begin
          k = seg_idx_t'(i) + amt;
          dout[i*WL_SEG_W +: WL_SEG_W] = din[k*WL_SEG_W +: WL_SEG_W];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wlv_seg_mask.sv
module wlv_seg_mask
  import wlv_pkg::*;
(
  input  seg_idx_t             start,
  input  seg_idx_t             len_m1,
  output logic [WL_NSEG-1:0]   en
);
  always_comb begin
    seg_idx_t rel;
    en = '0;
    for (int j = 0; j < WL_NSEG; j++) begin
      rel   = seg_idx_t'(j) - start;
      en[j] = (rel <= len_m1);
    end
  end
endmodule

// File: rtl/wlv_meta_tbl.sv
module wlv_meta_tbl
  import wlv_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [SLOT_W-1:0]    upd_slot,
  input  seg_idx_t             upd_len_m1,
  output seg_idx_t             upd_start,
  output logic [WL_CNT_W-1:0]  upd_count,
  input  logic [SLOT_W-1:0]    look_slot,
  output seg_idx_t             look_start,
  output seg_idx_t             look_len_m1
);
  localparam logic [WL_CNT_W-1:0] CNT_MAX = '1;

  slot_meta_t tbl [NUM_SLOTS];
  slot_meta_t cur;

  assign cur         = tbl[upd_slot];
  assign upd_start   = cur.start + cur.len_m1 + seg_idx_t'(1);
  assign upd_count   = (cur.wcount == CNT_MAX) ? CNT_MAX : cur.wcount + 1'b1;
  assign look_start  = tbl[look_slot].start;
  assign look_len_m1 = tbl[look_slot].len_m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        tbl[s].start  <= '0;
        tbl[s].len_m1 <= '1;
        tbl[s].wcount <= '0;
      end
    end else if (upd_en) begin
      tbl[upd_slot].start  <= upd_start;
      tbl[upd_slot].len_m1 <= upd_len_m1;
      tbl[upd_slot].wcount <= upd_count;
    end
  end

  // R7: a full counter stays full after another write
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && cur.wcount == CNT_MAX |=> tbl[$past(upd_slot)].wcount == CNT_MAX);
endmodule

// File: rtl/rot_wear_leveler.sv
module rot_wear_leveler
  import wlv_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [WL_IDX_W-1:0]   wr_len_m1,
  input  logic [WL_LINE_W-1:0]  wr_data,
  output logic                  dw_valid,
  input  logic                  dw_ready,
  output logic [SLOT_W-1:0]     dw_slot,
  output logic [WL_LINE_W-1:0]  dw_data,
  output logic [WL_NSEG-1:0]    dw_seg_en,
  output logic [WL_CNT_W-1:0]   dw_count,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [SLOT_W-1:0]     rd_slot,
  input  logic [WL_LINE_W-1:0]  rd_raw,
  output logic                  rq_valid,
  input  logic                  rq_ready,
  output logic [WL_LINE_W-1:0]  rq_data,
  output logic [WL_IDX_W-1:0]   rq_len_m1
);
  logic                 wr_fire, rd_fire;
  seg_idx_t             new_start, rd_start, rd_len;
  logic [WL_CNT_W-1:0]  new_count;
  logic [WL_LINE_W-1:0] placed, aligned;
  logic [WL_NSEG-1:0]   en_mask;

  assign wr_ready = !dw_valid || dw_ready;
  assign rd_ready = !rq_valid || rq_ready;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  wlv_meta_tbl #(.NUM_SLOTS(NUM_SLOTS)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (wr_fire),
    .upd_slot   (wr_slot),
    .upd_len_m1 (wr_len_m1),
    .upd_start  (new_start),
    .upd_count  (new_count),
    .look_slot  (rd_slot),
    .look_start (rd_start),
    .look_len_m1(rd_len)
  );

  wlv_seg_rot #(.TO_SLOT(1'b1)) u_place (
    .din (wr_data),
    .amt (new_start),
    .dout(placed)
  );

  wlv_seg_rot #(.TO_SLOT(1'b0)) u_align (
    .din (rd_raw),
    .amt (rd_start),
    .dout(aligned)
  );

  wlv_seg_mask u_mask (
    .start (new_start),
    .len_m1(wr_len_m1),
    .en    (en_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw_valid  <= 1'b0;
      dw_slot   <= '0;
      dw_data   <= '0;
      dw_seg_en <= '0;
      dw_count  <= '0;
    end else if (wr_fire) begin
      dw_valid  <= 1'b1;
      dw_slot   <= wr_slot;
      dw_data   <= placed;
      dw_seg_en <= en_mask;
      dw_count  <= new_count;
    end else if (dw_ready) begin
      dw_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_valid  <= 1'b0;
      rq_data   <= '0;
      rq_len_m1 <= '0;
    end else if (rd_fire) begin
      rq_valid  <= 1'b1;
      rq_data   <= aligned;
      rq_len_m1 <= rd_len;
    end else if (rq_ready) begin
      rq_valid  <= 1'b0;
    end
  end

  // R1: outputs idle right after reset
  p_idle_after_rst_r1: assert property (@(posedge clk)
    !rst_n |=> !dw_valid && !rq_valid);

  // R9: stalled device write holds its contents
  p_dw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && !dw_ready |=> dw_valid && $stable(dw_data) && $stable(dw_seg_en)
                              && $stable(dw_count) && $stable(dw_slot));

  // R9: stalled aligned read holds its contents
  p_rq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_data) && $stable(rq_len_m1));

  // R5: the number of enables matches the accepted length
  p_en_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> $countones(dw_seg_en) == int'($past(wr_len_m1)) + 1);
endmodule

// File: tb/rot_wear_leveler_tb.sv
module rot_wear_leveler_tb;
  localparam int NS = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_valid = 0, dw_ready = 1, rd_valid = 0, rq_ready = 1;
  logic [SW-1:0] wr_slot = '0, rd_slot = '0;
  logic [3:0]    wr_len_m1 = '0;
  logic [511:0]  wr_data = '0, rd_raw = '0;
  logic          wr_ready, rd_ready, dw_valid, rq_valid;
  logic [SW-1:0] dw_slot;
  logic [511:0]  dw_data, rq_data;
  logic [15:0]   dw_seg_en, dw_count;
  logic [3:0]    rq_len_m1;

  rot_wear_leveler #(.NUM_SLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_slot(wr_slot),
    .wr_len_m1(wr_len_m1), .wr_data(wr_data),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_slot(dw_slot),
    .dw_data(dw_data), .dw_seg_en(dw_seg_en), .dw_count(dw_count),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_slot(rd_slot), .rd_raw(rd_raw),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_data(rq_data), .rq_len_m1(rq_len_m1)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_start[NS], m_len[NS], m_cnt[NS];
  bit          m_dw_valid, m_rq_valid;
  int          m_dw_slot, m_dw_cnt, m_rq_len;
  logic [511:0] m_dw_data, m_rq_data;
  logic [15:0] m_dw_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin m_start[s] = 0; m_len[s] = 16; m_cnt[s] = 0; end
      m_dw_valid = 0; m_rq_valid = 0;
    end else begin
      bit wf, rf;
      wf = wr_valid && (!m_dw_valid || dw_ready);
      rf = rd_valid && (!m_rq_valid || rq_ready);
      if (rf) begin
        int b;
        b = m_start[rd_slot];
        for (int i = 0; i < 16; i++)
          m_rq_data[i*32 +: 32] = rd_raw[((b + i) % 16)*32 +: 32];
        m_rq_len = m_len[rd_slot] - 1;
        m_rq_valid = 1;
      end else if (rq_ready) m_rq_valid = 0;
      if (wf) begin
        int b, n;
        b = (m_start[wr_slot] + m_len[wr_slot]) % 16;
        n = int'(wr_len_m1) + 1;
        m_start[wr_slot] = b;
        m_len[wr_slot] = n;
        if (m_cnt[wr_slot] < 65535) m_cnt[wr_slot]++;
        m_dw_data = '0; m_dw_en = '0;
        for (int i = 0; i < 16; i++)
          m_dw_data[((b + i) % 16)*32 +: 32] = wr_data[i*32 +: 32];
        for (int i = 0; i < n; i++) m_dw_en[(b + i) % 16] = 1'b1;
        m_dw_slot = wr_slot; m_dw_cnt = m_cnt[wr_slot]; m_dw_valid = 1;
      end else if (dw_ready) m_dw_valid = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(dw_valid == m_dw_valid, "R9 dw_valid", 512'(dw_valid), 512'(m_dw_valid));
      chk(rq_valid == m_rq_valid, "R9 rq_valid", 512'(rq_valid), 512'(m_rq_valid));
      if (m_dw_valid) begin
        chk(dw_data == m_dw_data, "R4 dw_data", dw_data, m_dw_data);
        chk(dw_seg_en == m_dw_en, "R5 dw_seg_en", 512'(dw_seg_en), 512'(m_dw_en));
        chk(int'(dw_count) == m_dw_cnt, "R6 dw_count", 512'(dw_count), 512'(m_dw_cnt));
        chk(int'(dw_slot) == m_dw_slot, "R6 dw_slot", 512'(dw_slot), 512'(m_dw_slot));
      end
      if (m_rq_valid) begin
        chk(rq_data == m_rq_data, "R8 rq_data", rq_data, m_rq_data);
        chk(int'(rq_len_m1) == m_rq_len, "R8 rq_len_m1", 512'(rq_len_m1), 512'(m_rq_len));
      end
      chk(wr_ready == (!dw_valid || dw_ready), "R9 wr_ready", 512'(wr_ready),
          512'(!dw_valid || dw_ready));
    end
  end

  function automatic logic [511:0] rnd_line();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic do_write(input int slot, input int lm1);
    @(negedge clk); #2;
    wr_valid = 1; wr_slot = SW'(slot); wr_len_m1 = 4'(lm1); wr_data = rnd_line();
    #1;
    while (!wr_ready) begin @(negedge clk); #3; end
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic do_read(input int slot);
    @(negedge clk); #2;
    rd_valid = 1; rd_slot = SW'(slot); rd_raw = rnd_line();
    #1;
    while (!rd_ready) begin @(negedge clk); #3; end
    @(posedge clk); #1 rd_valid = 0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dw_valid && !rq_valid, "R1 idle in reset", 512'({dw_valid, rq_valid}), 512'(0));
    #2 rst_n = 1;
    @(negedge clk);
    chk(!dw_valid && !rq_valid, "R1 idle after reset", 512'({dw_valid, rq_valid}), 512'(0));

    do_read(3); @(negedge clk);
    chk(rq_len_m1 == 4'd15, "R1 fresh slot length", 512'(rq_len_m1), 512'(15));

    do_write(2, 4); @(negedge clk);
    chk(dw_seg_en == 16'h001F, "R2 first write at 0", 512'(dw_seg_en), 512'(16'h001F));
    do_write(2, 2); @(negedge clk);
    chk(dw_seg_en == 16'h00E0, "R3 chained start 5", 512'(dw_seg_en), 512'(16'h00E0));
    do_write(2, 9); @(negedge clk);
    chk(dw_seg_en == 16'hFF03, "R4 wrap enables", 512'(dw_seg_en), 512'(16'hFF03));
    do_write(2, 15); @(negedge clk);
    chk(dw_seg_en == 16'hFFFF, "R5 full line", 512'(dw_seg_en), 512'(16'hFFFF));
    chk(dw_count == 16'd4, "R6 count after 4 writes", 512'(dw_count), 512'(4));
    do_read(2); @(negedge clk);
    chk(rq_data[31:0] == rd_raw[95:64], "R8 aligned seg0 from seg2",
        512'(rq_data[31:0]), 512'(rd_raw[95:64]));
    do_read(5); @(negedge clk);
    chk(rq_data == rd_raw, "R10 other slot untouched", rq_data, rd_raw);

    // back-pressure
    @(negedge clk); #2 dw_ready = 0;
    do_write(6, 3);
    fork
      do_write(6, 7);
      begin repeat (4) @(negedge clk); #2 dw_ready = 1; end
    join
    @(negedge clk);
    chk(dw_seg_en == 16'h0FF0, "R9 stalled then start 4", 512'(dw_seg_en), 512'(16'h0FF0));

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk); #2;
      wr_valid = $urandom_range(0, 1); wr_slot = SW'($urandom_range(0, NS - 1));
      wr_len_m1 = 4'($urandom); wr_data = rnd_line();
      rd_valid = $urandom_range(0, 1); rd_slot = SW'($urandom_range(0, 3));
      rd_raw = rnd_line();
      dw_ready = ($urandom_range(0, 3) != 0); rq_ready = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk); #2 wr_valid = 0; rd_valid = 0; dw_ready = 1; rq_ready = 1;
    repeat (2) @(negedge clk);

    // saturation
    #2 wr_valid = 1; wr_slot = SW'(7); wr_len_m1 = 4'd0;
    for (int c = 0; c < 65540; c++) begin
      @(posedge clk); #1 wr_data = rnd_line();
    end
    @(negedge clk);
    chk(dw_count == 16'hFFFF, "R7 counter saturated", 512'(dw_count), 512'(16'hFFFF));
    #2 wr_valid = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule